// File: doc/BRIEF.md
# Per-CPU Interrupt Delivery Unit

This block holds the interrupt state for a single processor inside a multiprocessor interrupt controller. A router upstream hands it requests that have already been routed to this CPU. Each request names a source, a priority and a vector. The unit decides whether to keep each request and whether the CPU must be interrupted. It drives a single interrupt line towards the processor.

The unit keeps two per-source bit sets. The pending set holds requests that are waiting to be taken. The in-service set holds sources the CPU has taken but has not yet finished. The CPU side uses three operations on a register-style port:

- It can write its task priority, which acts as a threshold.
- It can perform an acknowledge read, which returns a vector.
- It can signal end of interrupt, which retires the top in-service source.

When several pending sources share the highest priority, the one with the lowest index wins. The search for it is combinational and takes one cycle.

Top module: `irq_cpu_deliver`

## Requirements
- R1: After reset, `irq_out`, `req_accept`, `req_missed` and `ack_valid` are 0. `task_prio` is all ones (0xF for 4-bit priorities). The pending and in-service sets are empty, so an acknowledge straight after reset returns `SPUR_VEC`.
- R2: A task-priority write with value v makes `task_prio` equal v in the following cycle.
- R3: A request whose priority is less than or equal to the task priority is dropped. No pulse appears on `req_accept` or `req_missed`, and the source does not become pending.
- R4: A request for a source that is already pending is refused. `req_missed` pulses for one cycle, and the vector stored for that source is kept.
- R5: A request above the task priority, for a source that is not pending, is kept. The source becomes pending, and `req_accept` pulses for one cycle in the next cycle.
- R6: The cycle after a kept request, `irq_out` rises if both of these hold; otherwise `irq_out` keeps its value:
  - the request's priority is at least the highest pending priority held before it;
  - no in-service source has a priority above it.
- R7: The cycle after an acknowledge read:
  - `irq_out` is 0 and `ack_valid` is 1;
  - `ack_vec` holds the vector of the highest-priority pending source, with ties going to the lowest source index;
  - that source has moved from the pending set to the in-service set.
- R8: An acknowledge while nothing is pending returns `SPUR_VEC` and changes neither set.
- R9: End of interrupt clears the highest-priority in-service source. The next cycle, `irq_out` rises if a pending source exists and either nothing is left in service or that source's priority is above the new highest in-service priority. Otherwise `irq_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Routed request present this cycle |
| req_src | input | SRC_W | Source index of the request |
| req_prio | input | PRIO_W | Priority of the request |
| req_vec | input | VEC_W | Vector of the request |
| req_accept | output | 1 | One-cycle pulse: request kept, source now active |
| req_missed | output | 1 | One-cycle pulse: request refused because the source was already pending |
| tp_wr | input | 1 | Task-priority write strobe |
| tp_wdata | input | PRIO_W | Task-priority write value |
| task_prio | output | PRIO_W | Current task priority |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_valid | output | 1 | One-cycle pulse: `ack_vec` is valid |
| ack_vec | output | VEC_W | Acknowledged vector, or the spurious vector |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| irq_out | output | 1 | Interrupt line to the CPU |

## Verification
The assertions assume that at most one of `req_valid`, `tp_wr`, `ack_rd` and `eoi_wr` is high in any cycle, and one checker property flags any violation. The bench issues exactly one operation per cycle to keep within that assumption. The bench also keeps `req_src` below `NUM_SRC`. Under these conditions a reference model in the bench can track the pending set, the in-service set and the interrupt line operation by operation.

// File: rtl/irq_cpu_pkg.sv
package irq_cpu_pkg;
   localparam int unsigned DEF_NUM_SRC = 32;
   localparam int unsigned DEF_PRIO_W  = 4;
   localparam int unsigned DEF_VEC_W   = 8;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned N  = 32,
   parameter int unsigned PW = 4,
   localparam int unsigned IW = irq_cpu_pkg::idx_width(N)
) (
   input  logic [N-1:0]         mask,
   input  logic [N-1:0][PW-1:0] prio,
   output logic                 found,
   output logic [IW-1:0]        idx,
   output logic [PW-1:0]        best
);
   // descending scan with >= leaves the lowest index among equal priorities
   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i] && (!found || prio[i] >= best)) begin
            found = 1'b1;
            idx   = i[IW-1:0];
            best  = prio[i];
         end
      end
   end
endmodule

// File: rtl/irq_cpu_deliver.sv
module irq_cpu_deliver #(
   parameter int unsigned NUM_SRC  = irq_cpu_pkg::DEF_NUM_SRC,
   parameter int unsigned PRIO_W   = irq_cpu_pkg::DEF_PRIO_W,
   parameter int unsigned VEC_W    = irq_cpu_pkg::DEF_VEC_W,
   parameter logic [VEC_W-1:0] SPUR_VEC = '1,
   localparam int unsigned SRC_W = irq_cpu_pkg::idx_width(NUM_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [SRC_W-1:0]  req_src,
   input  logic [PRIO_W-1:0] req_prio,
   input  logic [VEC_W-1:0]  req_vec,
   output logic              req_accept,
   output logic              req_missed,
   input  logic              tp_wr,
   input  logic [PRIO_W-1:0] tp_wdata,
   output logic [PRIO_W-1:0] task_prio,
   input  logic              ack_rd,
   output logic              ack_valid,
   output logic [VEC_W-1:0]  ack_vec,
   input  logic              eoi_wr,
   output logic              irq_out
);
   generate
      if (NUM_SRC < 2) begin : g_bad_src
         $error("NUM_SRC must be at least 2");
      end
      if (PRIO_W < 1 || VEC_W < 1) begin : g_bad_w
         $error("PRIO_W and VEC_W must be positive");
      end
   endgenerate

   logic [NUM_SRC-1:0]             pend_q, svc_q, svc_after;
   logic [NUM_SRC-1:0][PRIO_W-1:0] pprio_q, sprio_q;
   logic [NUM_SRC-1:0][VEC_W-1:0]  pvec_q;
   logic [PRIO_W-1:0]              tp_q;

   logic              p_found, s_found, a_found;
   logic [SRC_W-1:0]  p_idx, s_idx, a_idx;
   logic [PRIO_W-1:0] p_best, s_best, a_best;

   irq_prio_pick #(.N(NUM_SRC), .PW(PRIO_W)) u_pick_pend (
      .mask(pend_q), .prio(pprio_q), .found(p_found), .idx(p_idx), .best(p_best));
   irq_prio_pick #(.N(NUM_SRC), .PW(PRIO_W)) u_pick_svc (
      .mask(svc_q), .prio(sprio_q), .found(s_found), .idx(s_idx), .best(s_best));

   // in-service set as it will be once the top entry is retired
   always_comb begin
      svc_after = svc_q;
      if (s_found) svc_after[s_idx] = 1'b0;
   end

   irq_prio_pick #(.N(NUM_SRC), .PW(PRIO_W)) u_pick_after (
      .mask(svc_after), .prio(sprio_q), .found(a_found), .idx(a_idx), .best(a_best));

   logic above_tp, accept_go, miss_go, ack_go, eoi_go, raise_new, raise_eoi;

   always_comb begin
      above_tp  = req_prio > tp_q;
      accept_go = req_valid && above_tp && !pend_q[req_src];
      miss_go   = req_valid && above_tp &&  pend_q[req_src];
      ack_go    = ack_rd && p_found;
      eoi_go    = eoi_wr && s_found;
      raise_new = (req_prio >= (p_found ? p_best : '0)) &&
                  !(s_found && (req_prio < s_best));
      raise_eoi = p_found && (!a_found || (p_best > a_best));
   end

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend_q[i]  <= 1'b0;
               svc_q[i]   <= 1'b0;
               pprio_q[i] <= '0;
               pvec_q[i]  <= '0;
               sprio_q[i] <= '0;
            end else begin
               if (accept_go && (req_src == SRC_W'(i))) begin
                  pend_q[i]  <= 1'b1;
                  pprio_q[i] <= req_prio;
                  pvec_q[i]  <= req_vec;
               end else if (ack_go && (p_idx == SRC_W'(i))) begin
                  pend_q[i] <= 1'b0;
               end
               if (ack_go && (p_idx == SRC_W'(i))) begin
                  svc_q[i]   <= 1'b1;
                  sprio_q[i] <= pprio_q[i];
               end else if (eoi_go && (s_idx == SRC_W'(i))) begin
                  svc_q[i] <= 1'b0;
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tp_q       <= '1;
         req_accept <= 1'b0;
         req_missed <= 1'b0;
         ack_valid  <= 1'b0;
         ack_vec    <= '0;
         irq_out    <= 1'b0;
      end else begin
         req_accept <= accept_go;
         req_missed <= miss_go;
         ack_valid  <= ack_rd;
         if (tp_wr) tp_q <= tp_wdata;
         if (ack_rd) ack_vec <= p_found ? pvec_q[p_idx] : SPUR_VEC;
         if (ack_rd)                      irq_out <= 1'b0;
         else if (accept_go && raise_new) irq_out <= 1'b1;
         else if (eoi_wr && raise_eoi)    irq_out <= 1'b1;
      end
   end

   assign task_prio = tp_q;
endmodule

// File: rtl/irq_cpu_deliver_chk.sv
module irq_cpu_deliver_chk #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned VEC_W   = 8,
   localparam int unsigned SRC_W = irq_cpu_pkg::idx_width(NUM_SRC)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [SRC_W-1:0]  req_src,
   input logic [PRIO_W-1:0] req_prio,
   input logic              req_accept,
   input logic              req_missed,
   input logic              tp_wr,
   input logic [PRIO_W-1:0] tp_wdata,
   input logic [PRIO_W-1:0] task_prio,
   input logic              ack_rd,
   input logic              ack_valid,
   input logic              eoi_wr,
   input logic              irq_out,
   input logic [NUM_SRC-1:0] pend_q,
   input logic [NUM_SRC-1:0] svc_q
);
   // input rule: one operation per cycle
   one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_valid, tp_wr, ack_rd, eoi_wr}));

   // R2
   tp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tp_wr |=> task_prio == $past(tp_wdata));

   // R3
   low_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_prio <= task_prio) |=> !req_accept && !req_missed && $stable(pend_q));

   // R4
   miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_prio > task_prio) && pend_q[req_src] |=> req_missed && !req_accept);

   // R5
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_prio > task_prio) && !pend_q[req_src]
      |=> req_accept && ($countones(pend_q) == $countones($past(pend_q)) + 1));

   // R7
   ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_rd |=> ack_valid && !irq_out);

   // R8
   empty_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_rd && (pend_q == '0) |=> $stable(svc_q) && (pend_q == '0));

   // R9
   eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_wr && (svc_q != '0) |=> $countones(svc_q) == $countones($past(svc_q)) - 1);
endmodule

bind irq_cpu_deliver irq_cpu_deliver_chk #(
   .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
   .req_prio(req_prio), .req_accept(req_accept), .req_missed(req_missed),
   .tp_wr(tp_wr), .tp_wdata(tp_wdata), .task_prio(task_prio), .ack_rd(ack_rd),
   .ack_valid(ack_valid), .eoi_wr(eoi_wr), .irq_out(irq_out),
   .pend_q(pend_q), .svc_q(svc_q)
);

// File: tb/irq_cpu_deliver_tb.sv
`timescale 1ns/1ps
module irq_cpu_deliver_tb;
   localparam int N = 8;
   localparam int PW = 4;
   localparam int VW = 8;
   localparam logic [VW-1:0] SPUR = 8'hA5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, tp_wr = 1'b0, ack_rd = 1'b0, eoi_wr = 1'b0;
   logic [2:0] req_src = '0;
   logic [PW-1:0] req_prio = '0, tp_wdata = '0;
   logic [VW-1:0] req_vec = '0;
   logic req_accept, req_missed, ack_valid, irq_out;
   logic [PW-1:0] task_prio;
   logic [VW-1:0] ack_vec;

   always #4 clk = ~clk;

   irq_cpu_deliver #(.NUM_SRC(N), .PRIO_W(PW), .VEC_W(VW), .SPUR_VEC(SPUR)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
      .req_prio(req_prio), .req_vec(req_vec), .req_accept(req_accept),
      .req_missed(req_missed), .tp_wr(tp_wr), .tp_wdata(tp_wdata),
      .task_prio(task_prio), .ack_rd(ack_rd), .ack_valid(ack_valid),
      .ack_vec(ack_vec), .eoi_wr(eoi_wr), .irq_out(irq_out));

   int checks = 0, fails = 0;
   bit m_pend[N], m_svc[N];
   int m_prio[N], m_vec[N], m_sprio[N];
   int m_tp;
   bit m_irq;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int top_pend();
      int b = -1;
      for (int i = 0; i < N; i++)
         if (m_pend[i] && (b < 0 || m_prio[i] > m_prio[b])) b = i;
      return b;
   endfunction

   function automatic int top_svc();
      int b = -1;
      for (int i = 0; i < N; i++)
         if (m_svc[i] && (b < 0 || m_sprio[i] > m_sprio[b])) b = i;
      return b;
   endfunction

   task automatic idle_all();
      req_valid = 0; tp_wr = 0; ack_rd = 0; eoi_wr = 0;
   endtask

   task automatic set_tp(input int v);
      tp_wr = 1; tp_wdata = PW'(v);
      @(negedge clk); idle_all();
      m_tp = v;
      chk("R2 task_prio", task_prio, v);
   endtask

   task automatic do_req(input int s, input int p, input int v);
      bit ea = 0, em = 0;
      int rb, sb, rmax;
      req_valid = 1; req_src = 3'(s); req_prio = PW'(p); req_vec = VW'(v);
      @(negedge clk); idle_all();
      if (p <= m_tp) begin
         // R3: dropped
      end else if (m_pend[s]) em = 1;      // R4
      else begin                           // R5 / R6
         ea = 1;
         rb = top_pend(); sb = top_svc();
         rmax = (rb < 0) ? 0 : m_prio[rb];
         if (p >= rmax && !(sb >= 0 && p < m_sprio[sb])) m_irq = 1;
         m_pend[s] = 1; m_prio[s] = p; m_vec[s] = v;
      end
      chk("R3/R5 req_accept", req_accept, ea);
      chk("R4 req_missed", req_missed, em);
      chk("R6 irq_out after request", irq_out, m_irq);
   endtask

   task automatic do_ack();
      int rb = top_pend();
      int ev;
      ack_rd = 1;
      @(negedge clk); idle_all();
      if (rb < 0) ev = SPUR;               // R8
      else begin
         ev = m_vec[rb];
         m_pend[rb] = 0; m_svc[rb] = 1; m_sprio[rb] = m_prio[rb];
      end
      m_irq = 0;
      chk("R7 ack_valid", ack_valid, 1);
      chk("R7/R8 ack_vec", ack_vec, ev);
      chk("R7 irq_out low after ack", irq_out, 0);
   endtask

   task automatic do_eoi();
      int sb = top_svc();
      int rb, sb2;
      eoi_wr = 1;
      @(negedge clk); idle_all();
      if (sb >= 0) m_svc[sb] = 0;
      rb = top_pend(); sb2 = top_svc();
      if (rb >= 0 && (sb2 < 0 || m_prio[rb] > m_sprio[sb2])) m_irq = 1;
      chk("R9 irq_out after eoi", irq_out, m_irq);
   endtask

   task automatic drain();
      for (int k = 0; k < N + 1; k++) do_ack();
      for (int k = 0; k < N + 1; k++) do_eoi();
   endtask

   initial begin
      #2000000;
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int lfsr = 32'h1ACE;
      m_tp = 15; m_irq = 0;
      for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_svc[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq_out", irq_out, 0);
      chk("R1 task_prio", task_prio, 15);
      chk("R1 req_accept", req_accept, 0);
      chk("R1 ack_valid", ack_valid, 0);
      do_ack();   // R1/R8 empty ack after reset gives spurious

      // sweep every threshold against every request priority
      for (int t = 0; t < 16; t++)
         for (int p = 0; p < 16; p++) begin
            set_tp(t);
            do_req(p % N, p, 16 * t + p);
            do_ack(); do_eoi(); do_eoi();
         end

      set_tp(0);
      // R4 miss keeps the first vector
      do_req(2, 5, 8'h11); do_req(2, 9, 8'h22); do_ack();
      drain();
      // R7 tie-break to lowest index
      do_req(6, 7, 8'h66); do_req(3, 7, 8'h33); do_req(5, 7, 8'h55);
      do_ack(); do_ack(); do_ack(); do_ack();
      drain();
      // R6 hidden by a higher in-service source, R9 release on eoi
      do_req(1, 12, 8'h01); do_ack();
      do_req(4, 6, 8'h04);
      do_eoi(); do_ack(); do_eoi();
      // R6 hidden by a higher pending source
      do_req(0, 10, 8'h70); do_ack(); do_req(1, 13, 8'h71); do_req(2, 3, 8'h72);
      drain();

      // pseudo-random mix of one operation per cycle
      for (int n = 0; n < 3000; n++) begin
         int op;
         lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
         op = lfsr & 7;
         if (op < 4) do_req((lfsr >> 4) & 7, (lfsr >> 8) & 15, (lfsr >> 12) & 255);
         else if (op < 6) do_ack();
         else if (op == 6) do_eoi();
         else set_tp((lfsr >> 16) & 7);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule